// File: doc/BRIEF.md
# Pipelined Synchronous SRAM With No Bus Turnaround

This block is a cycle-accurate, synthesizable model of a pipelined synchronous static RAM whose data bus can carry a read in one cycle and a write in the next, in any mix, with no idle cycle between them. Every control, address and data input is captured on the rising clock edge. A read returns its word two enabled clock edges after its address is captured. A write takes its data from the input bus two enabled edges after its address is captured. Because both data phases sit at the same distance from their command, the read and write data phases of a mixed stream never collide.

Each new access starts with a load cycle, and advance cycles then continue it as a four-word burst in linear or interleaved order. Written data is parked in a one-entry holding register and reaches the array only when the next write's data arrives. Reads check that register byte by byte, so they always see the newest data. A low-active clock enable suspends the whole pipeline. Three chip selects decode the device for depth expansion.

The bus is modelled as separate input and output data ports. A drive-enable output shows when the block would drive the shared wires.

Top module: `pipe_sram`

## Requirements
- R1: A selected read whose address is captured at enabled edge k places its word on `rdata` at enabled edge k+2. From that edge until the next enabled edge, `rdata_drive` is high while `out_en_n` is low.
- R2: A selected write whose address is captured at enabled edge k takes `wdata` at enabled edge k+2. Only the byte lanes whose `byte_we_n` bit was 0 at edge k change. Lanes whose bit was 1 keep their old contents. Lane g is bits [g*BYTE_W +: BYTE_W].
- R3: Reads and writes may follow each other on consecutive cycles with no idle cycle. After any enabled edge at which write data is taken, `rdata_drive` is low.
- R4: While `clk_en_n` is 1, an edge changes nothing. `rdata`, `rdata_drive`, the burst position, the pipeline and the memory all hold.
- R5: A load cycle selects the device only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Any other load is a deselect: it drives no data two edges later and writes nothing.
- R6: An advance cycle (`load_n`=1) repeats the operation of the last load and ignores `rd_wrn`. Here `rd_wrn`=1 means read and 0 means write. An advance uses the next burst address and keeps the start address's upper bits. With `burst_il`=0, the low two bits are (start + count) mod 4.
- R7: With `burst_il`=1, the low two bits of an advance address are the start's low two bits XOR the burst count.
- R8: A read of an address whose write data has been taken but not yet stored in the array returns the new bytes for the written lanes and the older contents for the other lanes.
- R9: `out_en_n`=1 forces `rdata_drive` low at once, without waiting for a clock edge.
- R10: After reset, nothing is driven, no write is pending, and no burst is active, so advance cycles do nothing until a selected load.
- R11: The burst count wraps after four words, so the fifth word of a burst is at the start address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| clk_en_n | input | 1 | Low-active clock enable; high suspends the block |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | 0 starts a new access, 1 advances the burst |
| rd_wrn | input | 1 | 1 read, 0 write (sampled on load cycles) |
| byte_we_n | input | BYTES | Per-lane write enable, active low |
| addr | input | ADDR_W | Word address |
| burst_il | input | 1 | 0 linear burst order, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | BYTES*BYTE_W | Write data bus |
| rdata | output | BYTES*BYTE_W | Registered read data |
| rdata_drive | output | 1 | High when the block drives the data bus |

## Verification
The bench builds the block with its defaults: ADDR_W=8, BYTES=4 and BYTE_W=9. At 256 words, the bench can fill every word at the start and keep a full reference copy. That lets every later read be compared, including reads that follow deselected writes or advance cycles issued just after reset. The nine-bit lanes carry random parity bits, so lane merges under partial byte enables are checked on every bit. Addresses in the mixed phase are drawn from a 16-word window. This makes read-after-write to a word still in the holding register frequent, and it makes bursts that wrap inside a four-word group common in both orders.

// File: rtl/psram_pkg.sv
package psram_pkg;

   // Low two bits of a burst address from the start bits and the count.
   function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       il);
      return il ? (start ^ step) : (start + step);
   endfunction

endpackage

// File: rtl/psram_array.sv
module psram_array #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [BYTES-1:0]          wbe_n,
   input  logic [BYTES*BYTE_W-1:0]   wdat,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [BYTES*BYTE_W-1:0]   rdat
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && !wbe_n[g]) mem[waddr] <= wdat[g*BYTE_W +: BYTE_W];
      end
      assign rdat[g*BYTE_W +: BYTE_W] = mem[raddr];
   end
endmodule

// File: rtl/psram_burst.sv
module psram_burst
   import psram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ld_n,
   input  logic              sel,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTES-1:0]  be_n,
   input  logic              il,
   output logic              s1_vld,
   output logic              s1_wr,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [BYTES-1:0]  s1_be_n
);
   logic              b_vld, b_wr;
   logic [ADDR_W-1:0] b_base;
   logic [1:0]        b_cnt, nxt_cnt;

   assign nxt_cnt = b_cnt + 2'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_vld   <= 1'b0;
         b_wr    <= 1'b0;
         b_base  <= '0;
         b_cnt   <= '0;
         s1_vld  <= 1'b0;
         s1_wr   <= 1'b0;
         s1_addr <= '0;
         s1_be_n <= '1;
      end else if (en) begin
         s1_be_n <= be_n;
         if (!ld_n) begin
            b_vld   <= sel;
            b_wr    <= wr_req;
            b_base  <= addr;
            b_cnt   <= '0;
            s1_vld  <= sel;
            s1_wr   <= wr_req;
            s1_addr <= addr;
         end else begin
            b_cnt   <= nxt_cnt;
            s1_vld  <= b_vld;
            s1_wr   <= b_wr;
            s1_addr <= {b_base[ADDR_W-1:2], burst_lo(b_base[1:0], nxt_cnt, il)};
         end
      end
   end

   // R5: a deselected load leaves no live operation in the pipe
   p_deselect_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en && !ld_n && !sel |=> !s1_vld);

   // R6: an advance keeps the operation and the upper address bits of the load
   p_advance_keeps_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en && ld_n |=> s1_wr == $past(b_wr) && s1_addr[ADDR_W-1:2] == $past(b_base[ADDR_W-1:2]));
endmodule

// File: rtl/psram_wbuf.sv
module psram_wbuf #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    take,
   input  logic [ADDR_W-1:0]       t_addr,
   input  logic [BYTES-1:0]        t_be_n,
   input  logic [BYTES*BYTE_W-1:0] t_data,
   output logic                    arr_we,
   output logic [ADDR_W-1:0]       arr_addr,
   output logic [BYTES-1:0]        arr_be_n,
   output logic [BYTES*BYTE_W-1:0] arr_data,
   input  logic [ADDR_W-1:0]       q_addr,
   input  logic [BYTES*BYTE_W-1:0] q_raw,
   output logic [BYTES*BYTE_W-1:0] q_out
);
   logic                    hb_vld;
   logic [ADDR_W-1:0]       hb_addr;
   logic [BYTES-1:0]        hb_be_n;
   logic [BYTES*BYTE_W-1:0] hb_data;
   logic                    hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hb_vld  <= 1'b0;
         hb_addr <= '0;
         hb_be_n <= '1;
         hb_data <= '0;
      end else if (en && take) begin
         hb_vld  <= 1'b1;
         hb_addr <= t_addr;
         hb_be_n <= t_be_n;
         hb_data <= t_data;
      end
   end

   // The parked write reaches the array when the next write arrives.
   assign arr_we   = en && take && hb_vld;
   assign arr_addr = hb_addr;
   assign arr_be_n = hb_be_n;
   assign arr_data = hb_data;

   assign hit = hb_vld && (hb_addr == q_addr);

   for (genvar g = 0; g < BYTES; g++) begin : g_fwd
      assign q_out[g*BYTE_W +: BYTE_W] = (hit && !hb_be_n[g]) ?
         hb_data[g*BYTE_W +: BYTE_W] : q_raw[g*BYTE_W +: BYTE_W];
   end

   // R2: data taken for a write is parked with the address it belongs to
   p_park_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en && take |=> hb_vld && hb_addr == $past(t_addr) && hb_data == $past(t_data));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    cs_a_n,
   input  logic                    cs_b,
   input  logic                    cs_c_n,
   input  logic                    load_n,
   input  logic                    rd_wrn,
   input  logic [BYTES-1:0]        byte_we_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    burst_il,
   input  logic                    out_en_n,
   input  logic [BYTES*BYTE_W-1:0] wdata,
   output logic [BYTES*BYTE_W-1:0] rdata,
   output logic                    rdata_drive
);
   localparam int DW = BYTES * BYTE_W;

   if (ADDR_W < 2) begin : g_chk_aw
      $error("pipe_sram: ADDR_W must cover a four-word burst");
   end
   if (BYTES < 1 || BYTE_W < 1) begin : g_chk_lane
      $error("pipe_sram: lane count and width must be positive");
   end

   logic              en, sel;
   logic              s1_vld, s1_wr, s2_vld, s2_wr, rd_vld;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [BYTES-1:0]  s1_be_n, s2_be_n;
   logic              arr_we;
   logic [ADDR_W-1:0] arr_addr;
   logic [BYTES-1:0]  arr_be_n;
   logic [DW-1:0]     arr_data, arr_q, fwd_q;

   assign en  = !clk_en_n;
   assign sel = !cs_a_n && cs_b && !cs_c_n;

   psram_burst #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
      .clk(clk), .rst_n(rst_n), .en(en), .ld_n(load_n), .sel(sel),
      .wr_req(!rd_wrn), .addr(addr), .be_n(byte_we_n), .il(burst_il),
      .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_be_n(s1_be_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_vld  <= 1'b0;
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_be_n <= '1;
         rd_vld  <= 1'b0;
         rdata   <= '0;
      end else if (en) begin
         s2_vld  <= s1_vld;
         s2_wr   <= s1_wr;
         s2_addr <= s1_addr;
         s2_be_n <= s1_be_n;
         rd_vld  <= s2_vld && !s2_wr;
         if (s2_vld && !s2_wr) rdata <= fwd_q;
      end
   end

   psram_wbuf #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .en(en), .take(s2_vld && s2_wr),
      .t_addr(s2_addr), .t_be_n(s2_be_n), .t_data(wdata),
      .arr_we(arr_we), .arr_addr(arr_addr), .arr_be_n(arr_be_n), .arr_data(arr_data),
      .q_addr(s2_addr), .q_raw(arr_q), .q_out(fwd_q));

   psram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
      .clk(clk), .we(arr_we), .waddr(arr_addr), .wbe_n(arr_be_n), .wdat(arr_data),
      .raddr(s2_addr), .rdat(arr_q));

   assign rdata_drive = rd_vld && !out_en_n;

   // R1: a read in the last stage is on the bus after the next enabled edge
   p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      en && s2_vld && !s2_wr |=> rd_vld);

   // R3: the bus is never driven in the cycle after write data is taken
   p_no_drive_after_wdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en && s2_vld && s2_wr |=> !rdata_drive);

   // R4: a suspended edge leaves the outputs alone
   p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(rdata) && $stable(rd_vld));

   // R9: output enable high means no drive
   p_oe_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rdata_drive);
endmodule

// File: tb/sim_pipe_sram.sv
`timescale 1ns/1ps
module sim_pipe_sram;
   localparam int AW = 8;
   localparam int NB = 4;
   localparam int BW = 9;
   localparam int DW = NB * BW;

   typedef struct {
      logic          vld;
      logic          wr;
      logic [AW-1:0] addr;
      logic [NB-1:0] be;
      logic [DW-1:0] data;
   } ent_t;

   logic          clk = 0, rst_n = 0;
   logic          clk_en_n = 0, cs_a_n = 1, cs_b = 1, cs_c_n = 0;
   logic          load_n = 0, rd_wrn = 1, burst_il = 0, out_en_n = 0;
   logic [NB-1:0] byte_we_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdata_drive;

   pipe_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
      .cs_c_n(cs_c_n), .load_n(load_n), .rd_wrn(rd_wrn), .byte_we_n(byte_we_n),
      .addr(addr), .burst_il(burst_il), .out_en_n(out_en_n), .wdata(wdata),
      .rdata(rdata), .rdata_drive(rdata_drive));

   always #4 clk = ~clk;

   logic [DW-1:0] refm [1 << AW];
   ent_t          p1, p2;
   logic          bb_vld = 0, bb_wr = 0;
   logic [AW-1:0] bb_base = '0;
   logic [1:0]    bb_cnt = '0;
   logic          exp_vld = 0;
   logic [DW-1:0] exp_d = '0;
   int            checks = 0, fails = 0;
   string         cur_req = "R10";
   bit            done = 0;

   function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] be);
      logic [DW-1:0] r = old;
      for (int g = 0; g < NB; g++) if (!be[g]) r[g*BW +: BW] = nw[g*BW +: BW];
      return r;
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One clock: model the pipe, present write data, compare the bus afterwards.
   task automatic clock_step();
      ent_t          e;
      logic          en = !clk_en_n;
      logic [1:0]    nc = bb_cnt + 2'd1;
      logic          nb_vld = bb_vld, nb_wr = bb_wr;
      logic [AW-1:0] nb_base = bb_base;
      logic [1:0]    nb_cnt = nc;
      e.data = {4'($urandom()), 32'($urandom())};
      e.be = byte_we_n;
      if (!load_n) begin
         e.vld = !cs_a_n && cs_b && !cs_c_n;
         e.wr = !rd_wrn;
         e.addr = addr;
         nb_vld = e.vld; nb_wr = e.wr; nb_base = addr; nb_cnt = 2'd0;
      end else begin
         e.vld = bb_vld;
         e.wr = bb_wr;
         e.addr = {bb_base[AW-1:2], burst_il ? (bb_base[1:0] ^ nc) : (bb_base[1:0] + nc)};
      end
      wdata = p2.data;
      @(posedge clk);
      if (en) begin
         bb_vld = nb_vld; bb_wr = nb_wr; bb_base = nb_base; bb_cnt = nb_cnt;
         if (p2.vld && p2.wr) refm[p2.addr] = merge(refm[p2.addr], p2.data, p2.be);
         exp_vld = p2.vld && !p2.wr;
         if (exp_vld) exp_d = refm[p2.addr];
         p2 = p1;
         p1 = e;
      end
      @(negedge clk);
      check({cur_req, " drive"}, DW'(rdata_drive), DW'(exp_vld && !out_en_n));
      if (exp_vld) check({cur_req, " data"}, rdata, exp_d);
   endtask

   task automatic idle_in();
      clk_en_n = 0; load_n = 0; cs_a_n = 1; cs_b = 1; cs_c_n = 0;
      rd_wrn = 1; byte_we_n = '1; out_en_n = 0;
   endtask

   task automatic op(logic rd, logic [AW-1:0] a, logic [NB-1:0] be);
      idle_in();
      cs_a_n = 0; rd_wrn = rd; addr = a; byte_we_n = be;
      clock_step();
   endtask

   task automatic adv(logic [NB-1:0] be);
      idle_in();
      cs_a_n = 0; load_n = 1; rd_wrn = $urandom(); byte_we_n = be;
      clock_step();
   endtask

   task automatic nop(int n);
      for (int i = 0; i < n; i++) begin idle_in(); clock_step(); end
   endtask

   task automatic t_reset();
      cur_req = "R10";
      p1.vld = 0; p2.vld = 0; p1.data = '0; p2.data = '0;
      idle_in();
      repeat (3) @(negedge clk);
      rst_n = 1;
      check("R10 drive after reset", DW'(rdata_drive), '0);
      // advance cycles with no prior load must do nothing
      for (int i = 0; i < 3; i++) adv(4'h0);
      nop(2);
   endtask

   task automatic t_fill();
      cur_req = "R2";
      for (int a = 0; a < (1 << AW); a++) op(1'b0, AW'(a), 4'h0);
      nop(2);
      for (int a = 0; a < 8; a++) op(1'b1, AW'(a), 4'hF);
      nop(2);
   endtask

   task automatic t_read_latency();
      cur_req = "R1";
      op(1'b1, 8'h40, 4'hF);
      nop(3);
      op(1'b1, 8'h41, 4'hF);
      op(1'b1, 8'h42, 4'hF);
      nop(2);
   endtask

   task automatic t_partial_write();
      cur_req = "R2";
      op(1'b0, 8'h50, 4'b1010);
      op(1'b0, 8'h51, 4'b0111);
      op(1'b0, 8'h52, 4'b1111);
      nop(2);
      op(1'b1, 8'h50, 4'hF);
      op(1'b1, 8'h51, 4'hF);
      op(1'b1, 8'h52, 4'hF);
      nop(2);
   endtask

   task automatic t_alternate();
      cur_req = "R3";
      for (int i = 0; i < 20; i++) op(i[0], AW'(8'h60 + i), 4'h0);
      nop(2);
   endtask

   task automatic t_coherent();
      cur_req = "R8";
      op(1'b0, 8'h70, 4'b0101);
      op(1'b1, 8'h70, 4'hF);
      op(1'b1, 8'h70, 4'hF);
      op(1'b0, 8'h70, 4'b1110);
      op(1'b0, 8'h71, 4'b0000);
      op(1'b1, 8'h70, 4'hF);
      op(1'b1, 8'h71, 4'hF);
      nop(2);
   endtask

   task automatic t_burst_linear();
      cur_req = "R6";
      burst_il = 0;
      op(1'b0, 8'h82, 4'h0);
      for (int i = 0; i < 3; i++) adv(4'h0);
      cur_req = "R11";
      op(1'b1, 8'h82, 4'hF);
      for (int i = 0; i < 5; i++) adv(4'hF);
      nop(2);
   endtask

   task automatic t_burst_il();
      cur_req = "R7";
      op(1'b0, 8'h91, 4'h0);
      burst_il = 1;
      for (int i = 0; i < 3; i++) begin idle_in(); cs_a_n = 0; load_n = 1; burst_il = 1; byte_we_n = '0; clock_step(); end
      burst_il = 0;
      op(1'b1, 8'h93, 4'hF);
      for (int i = 0; i < 4; i++) begin idle_in(); cs_a_n = 0; load_n = 1; burst_il = 1; clock_step(); end
      burst_il = 0;
      op(1'b1, 8'h90, 4'hF);
      for (int i = 0; i < 3; i++) adv(4'hF);
      nop(2);
   endtask

   task automatic t_deselect();
      cur_req = "R5";
      for (int k = 0; k < 3; k++) begin
         idle_in();
         cs_a_n = (k == 0); cs_b = (k != 1); cs_c_n = (k == 2);
         rd_wrn = 0; addr = 8'hA0; byte_we_n = 4'h0;
         clock_step();
         idle_in();
         cs_a_n = (k == 0); cs_b = (k != 1); cs_c_n = (k == 2);
         rd_wrn = 1; addr = 8'hA0;
         clock_step();
         adv(4'h0);
      end
      nop(1);
      op(1'b1, 8'hA0, 4'hF);
      nop(2);
   endtask

   task automatic t_stall();
      cur_req = "R4";
      op(1'b1, 8'hB0, 4'hF);
      op(1'b0, 8'hB1, 4'h0);
      op(1'b1, 8'hB2, 4'hF);
      for (int i = 0; i < 3; i++) begin idle_in(); clk_en_n = 1; cs_a_n = 0; rd_wrn = 0; addr = 8'hB2; byte_we_n = '0; clock_step(); end
      op(1'b1, 8'hB1, 4'hF);
      for (int i = 0; i < 2; i++) begin idle_in(); clk_en_n = 1; clock_step(); end
      nop(3);
   endtask

   task automatic t_oe();
      cur_req = "R9";
      op(1'b1, 8'hC0, 4'hF);
      op(1'b1, 8'hC1, 4'hF);
      idle_in(); out_en_n = 1; clock_step();
      #2 out_en_n = 0; #1;
      check("R9 drive when enabled again", DW'(rdata_drive), DW'(1));
      out_en_n = 1; #1;
      check("R9 drive gated at once", DW'(rdata_drive), DW'(0));
      idle_in(); out_en_n = 1; clock_step();
      nop(2);
   endtask

   task automatic t_random_mix();
      cur_req = "R3";
      for (int i = 0; i < 600; i++) begin
         int c = $urandom_range(0, 9);
         idle_in();
         burst_il = $urandom();
         out_en_n = ($urandom_range(0, 7) == 0);
         byte_we_n = NB'($urandom());
         addr = AW'($urandom_range(0, 15));
         rd_wrn = $urandom();
         if (c < 5) cs_a_n = 0;
         else if (c < 8) begin cs_a_n = 0; load_n = 1; end
         else if (c == 8) clk_en_n = 1;
         clock_step();
      end
      nop(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_fill();
      t_read_latency();
      t_partial_write();
      t_alternate();
      t_coherent();
      t_burst_linear();
      t_burst_il();
      t_deselect();
      t_stall();
      t_oe();
      t_random_mix();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule